// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bus master that fetches a single 16-bit word from a small three-wire serial EEPROM that holds 64 words. A host places a 6-bit word address on the address input and pulses start. The reader then drives the memory's select, clock and serial input lines by itself, collects the sixteen returned bits and presents the word with a one-cycle done pulse. Only the read operation is generated. Writing, erasing and write-enable sequences are left to other logic.

Every pin transition is timed by a half-period counter that counts system clock cycles. The default spaces edges 40 us apart on a 100 MHz clock, and a short value can be chosen for fast simulation. A single transaction is a fixed series of half periods. First there is a select lead-in. Then a 9-bit read frame goes out, sixteen data clocks follow, and the transaction closes with a trailing clock given while the memory is deselected. A packed 4-bit pin vector is also provided so that the lines can be placed directly into a host pin register.

Top module: `mwr_reader`

## Requirements
- R1: After reset, and whenever the reader is idle, select, clock and data-in are low, busy and done are low, and the result word is zero until the first read completes.
- R2: A start pulse seen while idle is accepted at that clock edge. Busy is high from the next cycle until the cycle in which done is high, and busy is low in that done cycle.
- R3: A read begins with one half period in which select is high while clock and data-in stay low.
- R4: The command frame is 9 bits, equal to 0x180 OR the 6-bit address, sent most significant bit first. For each bit, data-in holds the bit for one half period with clock high and then one half period with clock low, while select stays high.
- R5: After the frame, data-in is low and sixteen clock pulses follow, each one half period high and one half period low. The data-out line is sampled in the last system cycle of each high half, and the first bit sampled becomes the most significant bit of the word.
- R6: After the sixteenth data pulse, one half period has clock high with select low, and then one half period has every line low. Done then rises for exactly one cycle, and the result output carries the sixteen sampled bits in that same cycle.
- R7: Each half period lasts exactly HALF_CYC system clock cycles, so a read keeps busy high for 53 × HALF_CYC cycles.
- R8: A start pulse that arrives while busy is ignored. Neither the address nor the pin sequence in progress changes.
- R9: The result output stays constant from one done pulse until the next done pulse, including during a following read.
- R10: A start pulse that arrives in the cycle in which done is high is accepted as a new read.
- R11: The pin vector carries clock in bit 0, select in bit 1, data-in in bit 2 and the data-out input in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one word read |
| addr_i | input | 6 | Word address, captured when the read is accepted |
| eep_do_i | input | 1 | Serial data returned by the memory |
| eep_cs_o | output | 1 | Memory select |
| eep_sk_o | output | 1 | Serial clock |
| eep_di_o | output | 1 | Serial data sent to the memory |
| pin_vec_o | output | 4 | Packed pin image {data-out, data-in, select, clock} |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle pulse when the word is valid |
| data_o | output | 16 | Word from the latest completed read |

## Verification
Two functions can land in the same cycle. One is the completion of a read, where done rises and busy drops. The other is the acceptance of a new start. The bench raises start in the exact cycle it sees done, and it also pulses start in the middle of a read with a different address. A behavioural model predicts every pin on every clock. It accepts the first start, ignores the mid-read one, and checks that the held result stays at the previous word until the new done.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int unsigned MWR_ADDR_W = 6;
  localparam int unsigned MWR_DATA_W = 16;
  localparam int unsigned MWR_CMD_W  = 9;
  localparam logic [MWR_CMD_W-1:0] MWR_READ_HDR = 9'h180;

  // half-period schedule: select lead-in, frame, data, tail
  localparam int unsigned MWR_NUM_PH_I = 1 + 2*MWR_CMD_W + 2*MWR_DATA_W + 2;
  localparam int unsigned MWR_PH_W     = $clog2(MWR_NUM_PH_I);
  localparam logic [MWR_PH_W-1:0] MWR_PH_CMD   = MWR_PH_W'(1);
  localparam logic [MWR_PH_W-1:0] MWR_PH_DATA  = MWR_PH_W'(1 + 2*MWR_CMD_W);
  localparam logic [MWR_PH_W-1:0] MWR_PH_TAILH = MWR_PH_W'(1 + 2*MWR_CMD_W + 2*MWR_DATA_W);
  localparam logic [MWR_PH_W-1:0] MWR_PH_TAILL = MWR_PH_W'(2 + 2*MWR_CMD_W + 2*MWR_DATA_W);
  localparam logic [MWR_PH_W-1:0] MWR_PH_LAST  = MWR_PH_TAILL;

  typedef enum logic [2:0] {
    SEG_SELECT,
    SEG_CMD,
    SEG_DATA,
    SEG_TAIL_HI,
    SEG_TAIL_LO
  } mwr_seg_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } mwr_pins_t;

  function automatic logic [MWR_CMD_W-1:0] mwr_frame(input logic [MWR_ADDR_W-1:0] a);
    return MWR_READ_HDR | {{(MWR_CMD_W-MWR_ADDR_W){1'b0}}, a};
  endfunction

  function automatic mwr_seg_e mwr_segment(input logic [MWR_PH_W-1:0] ph);
    if (ph < MWR_PH_CMD)        return SEG_SELECT;
    else if (ph < MWR_PH_DATA)  return SEG_CMD;
    else if (ph < MWR_PH_TAILH) return SEG_DATA;
    else if (ph == MWR_PH_TAILH) return SEG_TAIL_HI;
    else                        return SEG_TAIL_LO;
  endfunction

  // even offset inside a clocked segment is the high half
  function automatic logic mwr_high_half(input logic [MWR_PH_W-1:0] ph,
                                         input logic [MWR_PH_W-1:0] base);
    logic [MWR_PH_W-1:0] off;
    off = ph - base;
    return ~off[0];
  endfunction

  function automatic mwr_pins_t mwr_drive(input logic [MWR_PH_W-1:0] ph,
                                          input logic [MWR_CMD_W-1:0] frame);
    mwr_pins_t p;
    logic [MWR_PH_W-1:0] off;
    logic [MWR_CMD_W-1:0] sh;
    p = '0;
    off = ph - MWR_PH_CMD;
    sh = frame << (off >> 1);
    unique case (mwr_segment(ph))
      SEG_SELECT:  p.cs = 1'b1;
      SEG_CMD: begin
        p.cs = 1'b1;
        p.sk = mwr_high_half(ph, MWR_PH_CMD);
        p.di = sh[MWR_CMD_W-1];
      end
      SEG_DATA: begin
        p.cs = 1'b1;
        p.sk = mwr_high_half(ph, MWR_PH_DATA);
      end
      SEG_TAIL_HI: p.sk = 1'b1;
      default:     p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/mwr_halftimer.sv
module mwr_halftimer #(
  parameter int unsigned HALF_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == CNT_LAST);
  assign last_o = run_i & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R7
  AST_TIMER_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i && !restart_i |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/mwr_seq.sv
module mwr_seq
  import mwr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [MWR_ADDR_W-1:0] addr_i,
  input  logic                  half_last_i,
  output logic                  start_acc_o,
  output logic                  final_edge_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [MWR_PH_W-1:0]   ph_o,
  output logic [MWR_ADDR_W-1:0] addr_o
);
  logic                  busy_q, done_q;
  logic [MWR_PH_W-1:0]   ph_q;
  logic [MWR_ADDR_W-1:0] addr_q;

  assign start_acc_o  = start_i & ~busy_q;
  assign final_edge_o = busy_q & half_last_i & (ph_q == MWR_PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= '0;
      addr_q <= '0;
    end else begin
      done_q <= final_edge_o;
      if (start_acc_o) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        addr_q <= addr_i;
      end else if (final_edge_o) begin
        busy_q <= 1'b0;
      end else if (busy_q && half_last_i) begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign ph_o   = ph_q;
  assign addr_o = addr_q;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_q |=> busy_q && ph_q == '0); // R2
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !final_edge_o |=> busy_q && !done_q); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_i |=> $stable(addr_q)); // R8
  AST_START_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && start_i |=> busy_q); // R10
endmodule

// File: rtl/mwr_capture.sv
module mwr_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] shift_q, word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      word_q  <= '0;
    end else begin
      if (sample_i) shift_q <= {shift_q[DATA_W-2:0], bit_i};
      if (load_i)   word_q  <= shift_q;
    end
  end

  assign word_o = word_q;

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(word_q)); // R9
  AST_NO_SAMPLE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !sample_i); // R6
endmodule

// File: rtl/mwr_reader.sv
module mwr_reader
  import mwr_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [5:0]  addr_i,
  input  logic        eep_do_i,
  output logic        eep_cs_o,
  output logic        eep_sk_o,
  output logic        eep_di_o,
  output logic [3:0]  pin_vec_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] data_o
);
  logic                  half_last;
  logic                  start_acc;
  logic                  final_edge;
  logic                  busy;
  logic [MWR_PH_W-1:0]   ph;
  logic [MWR_ADDR_W-1:0] addr_q;
  logic [MWR_CMD_W-1:0]  frame;
  mwr_pins_t             pins;
  mwr_seg_e              seg;
  logic                  sample_now;

  mwr_halftimer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (start_acc),
    .run_i     (busy),
    .last_o    (half_last)
  );

  mwr_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .half_last_i  (half_last),
    .start_acc_o  (start_acc),
    .final_edge_o (final_edge),
    .busy_o       (busy),
    .done_o       (done_o),
    .ph_o         (ph),
    .addr_o       (addr_q)
  );

  assign frame = mwr_frame(addr_q);
  assign seg   = mwr_segment(ph);

  always_comb begin
    pins = '0;
    if (busy) pins = mwr_drive(ph, frame);
  end

  assign sample_now = busy & half_last & (seg == SEG_DATA) & pins.sk;

  mwr_capture #(.DATA_W(MWR_DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sample_now),
    .bit_i    (eep_do_i),
    .load_i   (final_edge),
    .word_o   (data_o)
  );

  assign eep_cs_o  = pins.cs;
  assign eep_sk_o  = pins.sk;
  assign eep_di_o  = pins.di;
  assign pin_vec_o = {eep_do_i, pins.di, pins.cs, pins.sk};
  assign busy_o    = busy;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !eep_cs_o && !eep_sk_o && !eep_di_o); // R1
  AST_SAMPLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> eep_sk_o && eep_cs_o && !eep_di_o); // R5
  AST_LEADIN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> eep_cs_o && !eep_sk_o && !eep_di_o); // R3
  AST_TAIL_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    final_edge |-> !eep_cs_o && !eep_sk_o); // R6
endmodule

// File: tb/mwr_reader_tb.sv
module mwr_reader_tb_top;
  localparam int H   = 3;
  localparam int TOT = 53 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  addr = '0;
  logic        miso = 1'b0;
  logic        cs_w, sk_w, di_w, busy_w, done_w;
  logic [3:0]  pv_w;
  logic [15:0] data_w;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mwr_reader #(.HALF_CYC(H)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .addr_i    (addr),
    .eep_do_i  (miso),
    .eep_cs_o  (cs_w),
    .eep_sk_o  (sk_w),
    .eep_di_o  (di_w),
    .pin_vec_o (pv_w),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .data_o    (data_w)
  );

  // behavioural memory contents
  logic [15:0] mem [64];
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 40503) ^ 16'h3C5A;
    mem[0]  = 16'hFFFF;
    mem[63] = 16'h0000;
    mem[21] = 16'hAAAA;
  end

  // behavioural serial memory
  int         ee_k = 0;
  logic [8:0] ee_cmd = '0;
  always @(posedge cs_w) begin ee_k = 0; ee_cmd = '0; end
  always @(negedge cs_w) miso = 1'b0;
  always @(posedge sk_w) begin
    if (cs_w) begin
      ee_k++;
      if (ee_k <= 9) ee_cmd = {ee_cmd[7:0], di_w};
      if (ee_k == 9) miso = 1'b0;
      else if (ee_k >= 10 && ee_k <= 25) miso = mem[ee_cmd[5:0]][25 - ee_k];
    end
  end

  // cycle model
  bit          m_busy = 0;
  bit          m_done = 0;
  int          m_cnt = 0;
  logic [5:0]  m_addr = '0;
  logic [15:0] m_word = '0;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_word = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == TOT - 1) begin
          m_busy = 0; m_done = 1; m_word = mem[m_addr];
        end else m_cnt++;
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_addr = addr;
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic expect_pins(output bit e_cs, output bit e_sk, output bit e_di, output string tag);
    int ph, j;
    logic [8:0] fr;
    e_cs = 0; e_sk = 0; e_di = 0; tag = "R1";
    if (m_busy) begin
      ph = m_cnt / H;
      fr = 9'h180 | {3'b000, m_addr};
      if (ph == 0) begin e_cs = 1; tag = "R3"; end
      else if (ph <= 18) begin
        j = ph - 1; e_cs = 1; e_sk = (j % 2 == 0); e_di = fr[8 - j/2]; tag = "R4";
      end else if (ph <= 50) begin
        j = ph - 19; e_cs = 1; e_sk = (j % 2 == 0); tag = "R5";
      end else if (ph == 51) begin e_sk = 1; tag = "R6"; end
      else tag = "R6";
    end
  endtask

  int busy_len = 0;
  always @(negedge clk) begin
    bit e_cs, e_sk, e_di;
    string tg;
    if (rst_n) begin
      expect_pins(e_cs, e_sk, e_di, tg);
      check(tg, "cs", int'(cs_w), int'(e_cs));
      check(tg, "sk", int'(sk_w), int'(e_sk));
      check(tg, "di", int'(di_w), int'(e_di));
      check("R2", "busy", int'(busy_w), int'(m_busy));
      check("R6", "done", int'(done_w), int'(m_done));
      check("R9", "data", int'(data_w), int'(m_word));
      check("R11", "pin_vec", int'(pv_w), int'({miso, e_di, e_cs, e_sk}));
      if (busy_w) busy_len++;
      if (done_w) begin
        check("R7", "busy length", busy_len, TOT);
        check("R4", "frame seen by memory", int'(ee_cmd), int'(9'h180 | {3'b000, m_addr}));
        busy_len = 0;
      end
    end
  end

  task automatic pulse_start(input logic [5:0] a);
    start = 1'b1; addr = a;
    @(negedge clk);
    start = 1'b0; addr = '0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_w);
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "cs in reset", int'(cs_w), 0);
    check("R1", "busy in reset", int'(busy_w), 0);
    check("R1", "data in reset", int'(data_w), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pulse_start(6'd0);  wait_done();   // all-ones word
    repeat (2) @(negedge clk);
    pulse_start(6'd63); wait_done();   // all-zeros word
    @(negedge clk);
    // R8: start mid-read with another address is ignored
    pulse_start(6'd21);
    repeat (40) @(negedge clk);
    pulse_start(6'd5);
    wait_done();
    check("R8", "word after ignored start", int'(data_w), int'(mem[21]));
    repeat (3) @(negedge clk);
    pulse_start(6'd42); wait_done();
    // R10: start in the done cycle
    pulse_start(6'd7);
    check("R10", "busy after start in done cycle", int'(busy_w), 1);
    check("R9", "result held during next read", int'(data_w), int'(mem[42]));
    wait_done();
    check("R5", "word msb first", int'(data_w), int'(mem[7]));
    pulse_start(6'd1); wait_done();
    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule